// File: doc/BRIEF.md
# Rank Activation and Write Spacing Guard

This block stands in front of all banks of one memory rank and decides, cycle by cycle, whether the command presented to it may go out. Row activations and writes to non-volatile cells both draw heavy current, and when many banks do them at once the peak supply current spikes. The guard therefore spaces these two command types across the whole rank, whatever bank they target. It enforces a rolling cap of four activations per window, a minimum gap between activations, a minimum gap between writes, and the two cross gaps write-then-activate and activate-then-write.

A scheduler offers one command per cycle on a valid/ready handshake: `cmd_valid` with `cmd_kind` and `cmd_bank`. `cmd_ready` reflects whether the presented kind may issue this cycle and is computed from `cmd_kind` whether or not `cmd_valid` is high. A command counts as issued, and enters the guard's history, only in a cycle where both `cmd_valid` and `cmd_ready` are high. A scheduler that sees `cmd_ready` low may hold the command, withdraw it or offer a different one; the guard keeps no memory of refused offers. When a command is held back, `stall_why` names the constraint with the most cycles still to wait.

Top module: `rank_cmd_guard`

## Requirements
- R1: With kind ACT (`cmd_kind`=1) presented, `cmd_ready` is low while fewer than T_FAW cycles have passed since the fourth most recent issued activation; a fifth activation therefore never issues within T_FAW cycles of the first of four.
- R2: An activation may issue no sooner than T_RRD cycles after the previous issued activation (issue at cycle t, next earliest at t+T_RRD), whatever banks both target.
- R3: With kind WRITE (`cmd_kind`=2) presented, a write may issue no sooner than T_WWD cycles after the previous issued write.
- R4: An activation may issue no sooner than T_WAD cycles after the previous issued write.
- R5: A write may issue no sooner than T_AWD cycles after the previous issued activation.
- R6: Kinds READ (`cmd_kind`=0) and PRECHARGE (`cmd_kind`=3) are always ready and report no stall reason.
- R7: `stall_why` is 0 when `cmd_ready` is high; otherwise it names the blocking constraint with the most cycles remaining, coded 1 four-activate window, 2 activate spacing, 3 write spacing, 4 write-to-activate, 5 activate-to-write; on a tie the lower code wins.
- R8: Only a handshake (`cmd_valid` and `cmd_ready` both high) is recorded; an offer with `cmd_valid` low or a refused command does not move any spacing window.
- R9: The target bank has no influence on the decision: all spacing applies across every bank of the rank.
- R10: After reset no history exists: every kind is ready and `stall_why` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_kind | input | 2 | 0 read, 1 activate, 2 write, 3 precharge |
| cmd_bank | input | BANK_W | Target bank, below NUM_BANKS |
| cmd_ready | output | 1 | The presented kind may issue this cycle |
| stall_why | output | 3 | Code of the dominant blocking constraint, 0 when ready |

## Verification
The guard is driven with activate-only bursts that press against the four-activate window and the activation gap, with write-heavy bursts that exercise write spacing, and with mixed traffic where writes and activations interleave so that the two cross gaps and ties between several constraints decide the stall reason. Directed sequences aim an activation at a second bank one cycle after the first to show that banks share one history, and offer commands with `cmd_valid` low to show that offers alone leave the windows untouched. Each cycle the ready flag and the stall code are compared with a model that keeps absolute issue times, so an off-by-one in any spacing or a wrong tie order shows at the first boundary cycle.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_ACT   = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_PRE   = 2'd3
  } cmd_kind_e;

  typedef enum logic [2:0] {
    WHY_NONE = 3'd0,
    WHY_FAW  = 3'd1,
    WHY_RRD  = 3'd2,
    WHY_WWD  = 3'd3,
    WHY_WAD  = 3'd4,
    WHY_AWD  = 3'd5
  } stall_why_e;

  // number of spacing rules, in tie order (index i reports code i+1)
  localparam int unsigned NUM_RULES = 5;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles still to wait given an age since the last event and a limit
  function automatic int unsigned wait_left(input int unsigned age, input int unsigned lim);
    return (age >= lim) ? 0 : (lim - age);
  endfunction

endpackage

// File: rtl/rcg_age_ctr.sv
module rcg_age_ctr #(
  parameter int unsigned MAXV = 20,
  parameter int unsigned W    = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] SAT = W'(MAXV);

  // age counts cycles since the last hit; saturated means "long ago"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= SAT;
    else if (hit)        age <= W'(1);
    else if (age != SAT) age <= age + W'(1);
  end

  assert_age_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age != '0) && (age <= SAT));

  assert_age_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (age == W'(1)));

endmodule

// File: rtl/rcg_faw_window.sv
module rcg_faw_window #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned MAXV  = 20,
  parameter int unsigned W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  output logic [W-1:0] oldest_age
);
  localparam logic [W-1:0] SAT = W'(MAXV);

  logic [W-1:0] ent [DEPTH];

  function automatic logic [W-1:0] bump(input logic [W-1:0] a);
    return (a == SAT) ? a : a + W'(1);
  endfunction

  // ent[0] is the youngest activation's age, ent[DEPTH-1] the oldest kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent[0] <= SAT;
    else        ent[0] <= push ? W'(1) : bump(ent[0]);
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent[i] <= SAT;
      else        ent[i] <= push ? bump(ent[i-1]) : bump(ent[i]);
    end

    assert_slot_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ent[i-1] <= ent[i]);
  end

  assign oldest_age = ent[DEPTH-1];

endmodule

// File: rtl/rcg_pick.sv
module rcg_pick #(
  parameter int unsigned N     = 5,
  parameter int unsigned W     = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0][W-1:0]  rem,
  output logic [IDX_W-1:0]     win,
  output logic [W-1:0]         best
);
  // strictly greater replaces: lowest index wins a tie
  always_comb begin
    win  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (rem[i] > best) begin
        best = rem[i];
        win  = IDX_W'(i);
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_chk
    assert_pick_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
      best >= rem[j]);
  end

endmodule

// File: rtl/rank_cmd_guard.sv
module rank_cmd_guard
  import rcg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 6,
  parameter int unsigned T_FAW     = 20,
  parameter int unsigned T_RRD     = 4,
  parameter int unsigned T_WWD     = 6,
  parameter int unsigned T_WAD     = 5,
  parameter int unsigned T_AWD     = 3,
  parameter int unsigned FAW_ACTS  = 4,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              cmd_ready,
  output logic [2:0]        stall_why
);
  localparam int unsigned TMAX  = max2(max2(max2(T_FAW, T_RRD), max2(T_WWD, T_WAD)), T_AWD);
  localparam int unsigned CNT_W = $clog2(TMAX + 1);
  localparam int unsigned IDX_W = $clog2(NUM_RULES);

  cmd_kind_e kind;
  assign kind = cmd_kind_e'(cmd_kind);

  logic fire, act_fire, wr_fire;
  assign fire     = cmd_valid && cmd_ready;
  assign act_fire = fire && (kind == KIND_ACT);
  assign wr_fire  = fire && (kind == KIND_WRITE);

  logic [CNT_W-1:0] act_age, wr_age, faw_age;

  rcg_age_ctr #(.MAXV(TMAX), .W(CNT_W)) u_act_age (
    .clk(clk), .rst_n(rst_n), .hit(act_fire), .age(act_age));

  rcg_age_ctr #(.MAXV(TMAX), .W(CNT_W)) u_wr_age (
    .clk(clk), .rst_n(rst_n), .hit(wr_fire), .age(wr_age));

  rcg_faw_window #(.DEPTH(FAW_ACTS), .MAXV(TMAX), .W(CNT_W)) u_faw (
    .clk(clk), .rst_n(rst_n), .push(act_fire), .oldest_age(faw_age));

  // remaining wait per rule, masked by whether the rule applies to the kind
  logic [NUM_RULES-1:0][CNT_W-1:0] rem;
  logic is_act, is_wr;
  assign is_act = (kind == KIND_ACT);
  assign is_wr  = (kind == KIND_WRITE);

  always_comb begin
    rem[0] = is_act ? CNT_W'(wait_left(32'(faw_age), T_FAW)) : '0;
    rem[1] = is_act ? CNT_W'(wait_left(32'(act_age), T_RRD)) : '0;
    rem[2] = is_wr  ? CNT_W'(wait_left(32'(wr_age),  T_WWD)) : '0;
    rem[3] = is_act ? CNT_W'(wait_left(32'(wr_age),  T_WAD)) : '0;
    rem[4] = is_wr  ? CNT_W'(wait_left(32'(act_age), T_AWD)) : '0;
  end

  logic [IDX_W-1:0] win;
  logic [CNT_W-1:0] best;

  rcg_pick #(.N(NUM_RULES), .W(CNT_W), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .rem(rem), .win(win), .best(best));

  logic act_ok, wr_ok;
  assign act_ok = (32'(faw_age) >= T_FAW) && (32'(act_age) >= T_RRD) && (32'(wr_age) >= T_WAD);
  assign wr_ok  = (32'(wr_age) >= T_WWD) && (32'(act_age) >= T_AWD);

  always_comb begin
    unique case (kind)
      KIND_ACT:   cmd_ready = act_ok;
      KIND_WRITE: cmd_ready = wr_ok;
      default:    cmd_ready = 1'b1;
    endcase
  end

  assign stall_why = (best == '0) ? WHY_NONE : 3'(32'(win) + 1);

  // ---- assertions ----
  assert_ready_matches_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == (stall_why == 3'd0));

  assert_passthru_kinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_act && !is_wr) |-> (cmd_ready && stall_why == 3'd0));

  assert_bank_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (32'(cmd_bank) < NUM_BANKS));

  if (T_RRD > 1) begin : g_rrd_chk
    assert_act_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |=> !act_ok);
  end
  if (T_WWD > 1) begin : g_wwd_chk
    assert_write_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !wr_ok);
  end
  if (T_WAD > 1) begin : g_wad_chk
    assert_write_then_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !act_ok);
  end
  if (T_AWD > 1) begin : g_awd_chk
    assert_act_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |=> !wr_ok);
  end

endmodule

// File: tb/tb_rank_cmd_guard.sv
module tb_rank_cmd_guard;

  localparam int NB    = 6;
  localparam int TFAW  = 20;
  localparam int TRRD  = 4;
  localparam int TWWD  = 6;
  localparam int TWAD  = 5;
  localparam int TAWD  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       cmd_ready;
  logic [2:0] stall_why;

  always #5 clk = ~clk;

  rank_cmd_guard #(.NUM_BANKS(NB), .T_FAW(TFAW), .T_RRD(TRRD), .T_WWD(TWWD),
                   .T_WAD(TWAD), .T_AWD(TAWD)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .stall_why(stall_why));

  int     n_checks = 0;
  int     n_fail   = 0;
  bit     finished = 0;
  longint now      = 0;
  longint last_act = -1000;
  longint last_wr  = -1000;
  longint hist [4] = '{-1000, -1000, -1000, -1000};

  function automatic int left(longint t, int lim);
    longint d = now - t;
    return (d >= lim) ? 0 : int'(lim - d);
  endfunction

  // expected stall code for a kind: largest remaining wait, lower code wins ties
  function automatic int exp_why(int kind);
    int best = 0, code = 0;
    int r [6];
    r[1] = left(hist[3], TFAW);
    r[2] = left(last_act, TRRD);
    r[3] = left(last_wr, TWWD);
    r[4] = left(last_wr, TWAD);
    r[5] = left(last_act, TAWD);
    for (int c = 1; c <= 5; c++) begin
      bit applies = (kind == 1) ? (c == 1 || c == 2 || c == 4)
                  : (kind == 2) ? (c == 3 || c == 5) : 1'b0;
      if (applies && r[c] > best) begin best = r[c]; code = c; end
    end
    return code;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, now, act, exp);
    end
  endtask

  task automatic step(bit v, int kind, int bank, string tag);
    int    why;
    bit    rdy;
    string t;
    @(negedge clk);
    cmd_valid = v;
    cmd_kind  = 2'(kind);
    cmd_bank  = 3'(bank);
    #1;
    why = exp_why(kind);
    rdy = (why == 0);
    if (tag != "") t = tag;
    else if (kind == 0 || kind == 3) t = "R6";
    else if (!rdy) t = $sformatf("R%0d", why);
    else t = (kind == 1) ? "R1" : "R3";
    check({t, " ready"}, int'(cmd_ready), int'(rdy));
    check("R7 stall_why", int'(stall_why), why);
    @(posedge clk);
    if (v && rdy) begin
      if (kind == 1) begin
        last_act = now;
        hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = now;
      end else if (kind == 2) begin
        last_wr = now;
      end
    end
    now++;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: empty history after reset
    step(0, 1, 0, "R10");
    step(0, 2, 0, "R10");
    step(0, 0, 0, "R10");

    // R9: second bank immediately after an activation is still spaced
    step(1, 1, 0, "R9");
    step(1, 1, 5, "R9");
    step(1, 1, 3, "R9");

    // R8: invalid offers and refused writes do not move the windows
    for (int i = 0; i < 8; i++) step(0, 2, i % NB, "R8");
    step(1, 2, 1, "R8");
    for (int i = 0; i < 3; i++) step(1, 2, 2, "R8");
    for (int i = 0; i < 30; i++) step(0, 1, 0, "R8");

    // R1/R2: back-to-back activation pressure
    for (int i = 0; i < 80; i++) step(1, 1, i % NB, "");

    // R7: write then activation pressure so cross gaps compete
    for (int i = 0; i < 40; i++) step(1, (i % 3 == 0) ? 2 : 1, 0, "");

    // random phases: act-heavy, write-heavy, mixed
    for (int ph = 0; ph < 30; ph++) begin
      for (int i = 0; i < 100; i++) begin
        int r = int'($urandom % 100);
        int k;
        case (ph % 3)
          0: k = (r < 80) ? 1 : int'($urandom % 4);
          1: k = (r < 80) ? 2 : int'($urandom % 4);
          default: k = int'($urandom % 4);
        endcase
        step(($urandom % 10) < 8, k, int'($urandom % NB), "");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule